// File: doc/BRIEF.md
# Interprocessor Mailbox

This peripheral lets several processors pass 32-bit words to one another through a set of independent hardware queues. A sender writes a word to a queue's message register and the word is appended. A receiver reads the same register and gets the oldest word, which is removed at the same time. Each queue also has a fill count and a full flag, both readable.

Four users each own an interrupt status register and an interrupt enable register. Every queue drives two event bits in each user's pair: one that reports a waiting message and one that reports free space. Software clears a status bit by writing a one to it. Each user has one interrupt line. The line is high whenever an enabled status bit is pending.

Access goes through a plain synchronous register port with address, write strobe, write data, read strobe and read data. The port has no back-pressure. Every access completes in the cycle its strobe is seen, and read data appears one cycle after the read strobe. A config register holds two idle-mode control bits. A revision register and a reset-done register are read-only.

Top module: `ipc_mailbox`

## Requirements
- R1: Writing the message register of queue n (byte address 0x40+4n, n = 0..5) appends the write data to that queue. Reading it returns the oldest stored word and removes that word, so words leave in the order they were written. The queues are independent of each other.
- R2: Each queue holds 4 words. A push is accepted only if the queue was not full at the start of that cycle. A rejected push changes neither the contents nor the count. A push and a pop of the same queue in one cycle are both applied.
- R3: A read of the message register of an empty queue returns 0 and leaves the queue unchanged.
- R4: The register at 0xC0+4n reads the number of words held in queue n. The register at 0x80+4n reads 1 when queue n holds 4 words and 0 otherwise.
- R5: User u (u = 0..3) has a status register at 0x100+8u and an enable register at 0x104+8u. In both, bit 2n is the message-waiting event of queue n and bit 2n+1 is its space-free event. A status bit is set on the clock edge after any cycle in which its condition holds. The condition for bit 2n is that queue n is non-empty. The condition for bit 2n+1 is that queue n is not full.
- R6: A write to a status register clears each bit written as 1 and leaves bits written as 0 untouched. In the cycle of the write, the clear takes precedence. If the condition still holds, the bit is set again on the following edge.
- R7: Output irq[u] is high exactly when user u has a status bit set whose enable bit is also set. Enable registers are read/write.
- R8: The config register at 0x10 stores bits 0 and 4 of a write and reads them back. All its other bits read 0.
- R9: The revision register at 0x00 reads 0x00000201. Writes to the revision, reset-done, full-flag and count registers are ignored.
- R10: The register at 0x14 reads 1 in bit 0 once reset has completed.
- R11: After reset all queues are empty, and all enable bits, config bits and irq outputs are 0.
- R12: Read data is registered and valid in the cycle after the read strobe. Addresses that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Byte address of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; pops when aimed at a message register |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| irq | output | 4 | Per-user interrupt, OR of enabled pending events |

## Verification
Two kinds of action can land in the same cycle.

The first is a push and a pop of one queue. The bench raises write and read strobes together on a message register, once with the queue full and once with it holding one word. It checks the returned word and the count that follows: a full queue must drop the new word and return its head, and a one-word queue must return the old word and keep the new one.

The second is a write-one clear of a status bit while the bit's condition is still true. The bench clears the message-waiting bit of a non-empty queue and the space-free bit of a full queue. It expects the first bit to reappear and the second to stay cleared.

A checker also confirms, on every cycle, that a cleared bit is zero after the clear edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int IDX_W      = 4;
  localparam int OFS_REV    = 'h000;
  localparam int OFS_CFG    = 'h010;
  localparam int OFS_SYS    = 'h014;
  localparam int OFS_MSG    = 'h040;
  localparam int OFS_FULL   = 'h080;
  localparam int OFS_CNT    = 'h0C0;
  localparam int OFS_USR    = 'h100;
  localparam int Q_STRIDE   = 4;
  localparam int USR_STRIDE = 8;
  localparam logic [31:0] CFG_RW_MASK = 32'h0000_0011;

  typedef enum logic [3:0] {
    RK_NONE, RK_REV, RK_CFG, RK_SYS, RK_MSG, RK_FULL, RK_CNT, RK_STS, RK_ENA
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_Q   = 6,
  parameter int NUM_USR = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    if (addr == ADDR_W'(OFS_REV)) sel.kind = RK_REV;
    if (addr == ADDR_W'(OFS_CFG)) sel.kind = RK_CFG;
    if (addr == ADDR_W'(OFS_SYS)) sel.kind = RK_SYS;
    for (int i = 0; i < NUM_Q; i++) begin
      if (addr == ADDR_W'(OFS_MSG + Q_STRIDE * i)) begin
        sel.kind = RK_MSG;
        sel.idx  = IDX_W'(i);
      end
      if (addr == ADDR_W'(OFS_FULL + Q_STRIDE * i)) begin
        sel.kind = RK_FULL;
        sel.idx  = IDX_W'(i);
      end
      if (addr == ADDR_W'(OFS_CNT + Q_STRIDE * i)) begin
        sel.kind = RK_CNT;
        sel.idx  = IDX_W'(i);
      end
    end
    for (int u = 0; u < NUM_USR; u++) begin
      if (addr == ADDR_W'(OFS_USR + USR_STRIDE * u)) begin
        sel.kind = RK_STS;
        sel.idx  = IDX_W'(u);
      end
      if (addr == ADDR_W'(OFS_USR + USR_STRIDE * u + 4)) begin
        sel.kind = RK_ENA;
        sel.idx  = IDX_W'(u);
      end
    end
  end
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_user_events.sv
module mbx_user_events #(
  parameter int NUM_Q = 6,
  localparam int EVW  = 2 * NUM_Q
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] has_msg,
  input  logic [NUM_Q-1:0] has_room,
  input  logic             clr_we,
  input  logic             ena_we,
  input  logic [EVW-1:0]   wdata,
  output logic [EVW-1:0]   sts,
  output logic [EVW-1:0]   ena,
  output logic             irq
);
  logic [EVW-1:0] cond;
  logic [EVW-1:0] clr_mask;

  for (genvar n = 0; n < NUM_Q; n++) begin : g_map
    assign cond[2*n]   = has_msg[n];
    assign cond[2*n+1] = has_room[n];
  end

  assign clr_mask = clr_we ? wdata : '0;
  assign irq      = |(sts & ena);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      ena <= '0;
    end else begin
      sts <= (sts | cond) & ~clr_mask;
      if (ena_we) ena <= wdata;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DW      = 32,
  parameter int ADDR_W  = 12,
  parameter int NUM_Q   = 6,
  parameter int NUM_USR = 4,
  parameter int DEPTH   = 4,
  parameter logic [DW-1:0] REV_ID = DW'(32'h0000_0201)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_rd,
  output logic [DW-1:0]      reg_rdata,
  output logic [NUM_USR-1:0] irq
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int EVW = 2 * NUM_Q;

  reg_sel_t sel;
  logic [NUM_Q-1:0]                q_push, q_pop, q_full, q_empty;
  logic [NUM_Q-1:0][DW-1:0]        q_head;
  logic [NUM_Q-1:0][CW-1:0]        q_count_all;
  logic [NUM_USR-1:0][EVW-1:0]     sts_all, ena_all;
  logic [DW-1:0]                   cfg, rd_mux;
  logic                            rst_done;

  mbx_decode #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .NUM_USR(NUM_USR)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign q_push[q] = reg_wr && (sel.kind == RK_MSG) && (sel.idx == IDX_W'(q));
    assign q_pop[q]  = reg_rd && (sel.kind == RK_MSG) && (sel.idx == IDX_W'(q));
    mbx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[q]),
      .pop   (q_pop[q]),
      .wdata (reg_wdata),
      .head  (q_head[q]),
      .count (q_count_all[q]),
      .full  (q_full[q]),
      .empty (q_empty[q])
    );
  end

  for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
    logic sts_we, ena_we;
    assign sts_we = reg_wr && (sel.kind == RK_STS) && (sel.idx == IDX_W'(u));
    assign ena_we = reg_wr && (sel.kind == RK_ENA) && (sel.idx == IDX_W'(u));
    mbx_user_events #(.NUM_Q(NUM_Q)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .has_msg  (~q_empty),
      .has_room (~q_full),
      .clr_we   (sts_we),
      .ena_we   (ena_we),
      .wdata    (reg_wdata[EVW-1:0]),
      .sts      (sts_all[u]),
      .ena      (ena_all[u]),
      .irq      (irq[u])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      rst_done <= 1'b0;
    end else begin
      rst_done <= 1'b1;
      if (reg_wr && sel.kind == RK_CFG) cfg <= reg_wdata & DW'(CFG_RW_MASK);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      RK_REV: rd_mux = REV_ID;
      RK_CFG: rd_mux = cfg;
      RK_SYS: rd_mux = DW'(rst_done);
      RK_MSG: begin
        for (int i = 0; i < NUM_Q; i++)
          if (sel.idx == IDX_W'(i) && !q_empty[i]) rd_mux = q_head[i];
      end
      RK_FULL: begin
        for (int i = 0; i < NUM_Q; i++)
          if (sel.idx == IDX_W'(i)) rd_mux = DW'(q_full[i]);
      end
      RK_CNT: begin
        for (int i = 0; i < NUM_Q; i++)
          if (sel.idx == IDX_W'(i)) rd_mux = DW'(q_count_all[i]);
      end
      RK_STS: begin
        for (int i = 0; i < NUM_USR; i++)
          if (sel.idx == IDX_W'(i)) rd_mux = DW'(sts_all[i]);
      end
      RK_ENA: begin
        for (int i = 0; i < NUM_USR; i++)
          if (sel.idx == IDX_W'(i)) rd_mux = DW'(ena_all[i]);
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DW      = 32,
  parameter int ADDR_W  = 12,
  parameter int NUM_Q   = 6,
  parameter int NUM_USR = 4,
  parameter int DEPTH   = 4,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int EVW    = 2 * NUM_Q
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic                        reg_wr,
  input logic [DW-1:0]               reg_wdata,
  input logic                        reg_rd,
  input logic [DW-1:0]               reg_rdata,
  input logic [NUM_USR-1:0]          irq,
  input logic [NUM_Q-1:0][CW-1:0]    q_count_all,
  input logic [NUM_USR-1:0][EVW-1:0] sts_all,
  input logic [NUM_USR-1:0][EVW-1:0] ena_all
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_qchk
    localparam int MSG_A = 'h40 + 4 * q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      q_count_all[q] <= CW'(DEPTH)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rd && reg_addr == ADDR_W'(MSG_A) && q_count_all[q] == CW'(DEPTH))
      |=> q_count_all[q] == CW'(DEPTH)); // R2

    AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && reg_addr == ADDR_W'(MSG_A) && q_count_all[q] == '0)
      |=> (reg_rdata == '0 && q_count_all[q] == '0)); // R3
  end

  for (genvar u = 0; u < NUM_USR; u++) begin : g_uchk
    localparam int STS_A = 'h100 + 8 * u;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_all[u] == '0) |-> !irq[u]); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(STS_A))
      |=> (sts_all[u] & $past(reg_wdata[EVW-1:0])) == '0); // R6

    for (genvar q = 0; q < NUM_Q; q++) begin : g_set
      AST_MSG_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count_all[q] != '0 && !(reg_wr && reg_addr == ADDR_W'(STS_A) && reg_wdata[2*q]))
        |=> sts_all[u][2*q]); // R5
    end
  end
endmodule

bind ipc_mailbox mbx_checker #(
  .DW(DW), .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .NUM_USR(NUM_USR), .DEPTH(DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .irq         (irq),
  .q_count_all (q_count_all),
  .sts_all     (sts_all),
  .ena_all     (ena_all)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
  localparam int NQ = 6, NU = 4, DEPTH = 4;
  localparam logic [31:0] REV   = 32'h0000_0201;
  localparam logic [31:0] IDLEV = 32'h0000_0AAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipc_mailbox uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [11:0] a_msg(int q);  return 12'('h40 + 4*q);  endfunction
  function automatic logic [11:0] a_full(int q); return 12'('h80 + 4*q);  endfunction
  function automatic logic [11:0] a_cnt(int q);  return 12'('hC0 + 4*q);  endfunction
  function automatic logic [11:0] a_sts(int u);  return 12'('h100 + 8*u); endfunction
  function automatic logic [11:0] a_ena(int u);  return 12'('h104 + 8*u); endfunction
  function automatic logic [31:0] word(int q, int i);
    return 32'hC0DE_0000 | 32'(q << 8) | 32'(i);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic brd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic bwrrd(logic [11:0] a, logic [31:0] wd, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = wd; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check("R11 irq after reset", 32'(irq), 32'h0);
    brd(12'h000, v); check("R9 revision", v, REV);
    bwr(12'h000, 32'hFFFF_FFFF); brd(12'h000, v); check("R9 revision write ignored", v, REV);
    brd(12'h014, v); check("R10 reset done", v, 32'h1);
    bwr(12'h014, 32'h0); brd(12'h014, v); check("R9 reset-done write ignored", v, 32'h1);
    brd(12'h010, v); check("R11 config reset", v, 32'h0);
    bwr(12'h010, 32'hFFFF_FFFF); brd(12'h010, v); check("R8 config mask", v, 32'h11);
    bwr(12'h010, 32'h0000_0010); brd(12'h010, v); check("R8 config bit4", v, 32'h10);
    brd(12'h03C, v); check("R12 unmapped read", v, 32'h0);
    for (int u = 0; u < NU; u++) begin
      brd(a_ena(u), v); check("R11 enable reset", v, 32'h0);
      brd(a_sts(u), v); check("R5 idle status", v, IDLEV);
    end
    for (int q = 0; q < NQ; q++) begin
      brd(a_cnt(q), v);  check("R11 count reset", v, 32'h0);
      brd(a_full(q), v); check("R11 full reset", v, 32'h0);
    end

    for (int q = 0; q < NQ; q++) begin
      int uu;
      uu = q % NU;
      for (int i = 0; i <= DEPTH; i++) begin
        bwr(a_msg(q), word(q, i));
        brd(a_cnt(q), v);
        check("R2 R4 count after push", v, 32'((i + 1 > DEPTH) ? DEPTH : i + 1));
      end
      brd(a_full(q), v); check("R4 full flag", v, 32'h1);
      bwr(a_cnt(q), 32'h0); brd(a_cnt(q), v); check("R9 count write ignored", v, 32'(DEPTH));
      brd(a_cnt((q + 1) % NQ), v); check("R1 queues independent", v, 32'h0);
      for (int u = 0; u < NU; u++) begin
        brd(a_sts(u), v); check("R5 message event", v, IDLEV | (32'h1 << (2*q)));
      end
      bwr(a_sts(0), 32'h1 << (2*q + 1)); brd(a_sts(0), v);
      check("R6 clear holds while full", v, (IDLEV & ~(32'h1 << (2*q + 1))) | (32'h1 << (2*q)));
      bwr(a_sts(1), 32'h1 << (2*q)); brd(a_sts(1), v);
      check("R6 clear then re-set", v, IDLEV | (32'h1 << (2*q)));
      bwr(a_sts(2), 32'h0); brd(a_sts(2), v);
      check("R6 zero write no effect", v, IDLEV | (32'h1 << (2*q)));
      bwr(a_ena(uu), 32'h1 << (2*q));
      check("R7 irq enabled", 32'(irq), 32'h1 << uu);
      brd(a_ena(uu), v); check("R7 enable readback", v, 32'h1 << (2*q));

      bwrrd(a_msg(q), 32'hDEAD_BEEF, v);
      check("R2 push+pop on full", v, word(q, 0));
      brd(a_cnt(q), v); check("R2 count after push+pop on full", v, 32'(DEPTH - 1));
      for (int i = 1; i < DEPTH; i++) begin
        brd(a_msg(q), v); check("R1 fifo order", v, word(q, i));
      end
      brd(a_msg(q), v); check("R3 pop empty", v, 32'h0);
      brd(a_cnt(q), v); check("R3 count stays zero", v, 32'h0);

      bwr(a_msg(q), 32'h1111_0000 + 32'(q));
      bwrrd(a_msg(q), 32'h2222_0000 + 32'(q), v);
      check("R2 push+pop returns old", v, 32'h1111_0000 + 32'(q));
      brd(a_cnt(q), v); check("R2 count after push+pop", v, 32'h1);
      brd(a_msg(q), v); check("R1 new word kept", v, 32'h2222_0000 + 32'(q));

      bwr(a_ena(uu), 32'h0);
      check("R7 irq masked", 32'(irq), 32'h0);
      for (int u = 0; u < NU; u++) begin
        bwr(a_sts(u), 32'h0000_0FFF);
        brd(a_sts(u), v); check("R6 clear all", v, IDLEV);
      end
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule